// File: doc/BRIEF.md
# Indexed Frame Data Buffer

This block holds the data bytes of one serial-bus response frame. The host side sees the whole array through one data port. A 3-bit index register chooses the byte, and a select register loads that index together with a step-mode bit. The step-mode bit is active low:
- 0 moves the index forward after each data-port access.
- 1 leaves the index where it is, so the host must reload it before the next byte.

The frame engine side fills or drains the array in frame order. It uses its own byte counter, which a start pulse returns to byte 0.

Both ports read combinationally. The host index and the engine counter are registers, and each one wraps from the last byte back to byte 0. When both sides write the same byte in the same cycle, the engine's byte is the one stored.

Top module: `fbuf_frame_buffer`

## Requirements
- R1: A host write stores `host_wdata` in the byte chosen by `cur_idx`. A later host read of that byte returns the stored value.
- R2: `host_rdata` shows, in the same cycle and without a clock edge, the byte selected by the current `cur_idx`.
- R3: When the step-mode bit is 0, every host access raises `cur_idx` by one at the next clock edge. A host access is a cycle with `host_rd` or `host_wr` high, and a cycle with both high counts as one access.
- R4: Both the host index and the engine counter go from 7 back to 0.
- R5: When the step-mode bit is 1, host accesses leave `cur_idx` unchanged.
- R6: A cycle with `sel_we` high loads `sel_idx` into `cur_idx` and `sel_hold` into the step-mode bit. Both take effect at the same edge.
- R7: If `sel_we` and a host access fall in the same cycle, the access uses the old index. The index then becomes `sel_idx`, with no increment.
- R8: `eng_start` points the engine counter at byte 0. Each `eng_wr` stores `eng_wdata` at the counter and moves the counter forward, so a frame's first byte lands at index 0, its second at index 1, and so on. When `eng_start` and an engine access share a cycle, the access goes to byte 0 and the counter moves to 1.
- R9: `eng_rdata` shows the byte at the engine counter combinationally. Each `eng_rd` moves the counter forward.
- R10: When host and engine write the same byte in the same cycle, the engine data is stored.
- R11: When host and engine write different bytes in the same cycle, both bytes are stored.
- R12: A synchronous reset sets `cur_idx` to 0, the step-mode bit to 1 (hold), and the engine counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Select register write strobe |
| sel_idx | input | 3 | Index value to load |
| sel_hold | input | 1 | Step-mode bit to load, active low: 0 steps, 1 holds |
| host_rd | input | 1 | Host data-port read |
| host_wr | input | 1 | Host data-port write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the current index |
| cur_idx | output | 3 | Current host index |
| eng_start | input | 1 | Response start, points the engine counter at byte 0 |
| eng_wr | input | 1 | Engine write, then advance |
| eng_wdata | input | 8 | Engine write byte |
| eng_rd | input | 1 | Engine read, then advance |
| eng_rdata | output | 8 | Byte at the engine counter |

## Verification
Two pairs of functions can coincide in one cycle.
- An index load and a host data access. The vector table provokes this with `sel_we` and `host_rd` or `host_wr` high together. It then judges two things: the read byte must come from the old index, and the following index must be exactly the loaded value.
- A host write and an engine write. Directed tests drive both write strobes in one cycle, first with both pointers on the same byte and then on different bytes. Host reads afterwards must show that the engine byte won on the shared byte and that both bytes landed when they differ.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int unsigned FB_DEPTH  = 8;
  localparam int unsigned FB_DATA_W = 8;

  typedef enum logic {
    STEP_AUTO = 1'b0,
    STEP_HOLD = 1'b1
  } step_mode_e;
endpackage

// File: rtl/fbuf_host_ptr.sv
module fbuf_host_ptr
  import fbuf_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             sel_hold,
  input  logic             access,
  output logic [IDX_W-1:0] idx,
  output step_mode_e       mode
);
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      mode <= STEP_HOLD;
    end else if (sel_we) begin
      idx  <= sel_idx;
      mode <= step_mode_e'(sel_hold);
    end else if (access && mode == STEP_AUTO) begin
      idx  <= idx + 1'b1;
    end
  end

  // R12: reset state of the index
  a_r12_reset_idx: assert property (@(posedge clk) rst |=> (idx == '0 && mode == STEP_HOLD));
  // R6: select write loads the index
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> idx == $past(sel_idx));
  // R5: hold mode keeps the index
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!sel_we && mode == STEP_HOLD) |=> $stable(idx));
  // R4: wrap from the last byte
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (!sel_we && access && mode == STEP_AUTO && idx == IDX_LAST) |=> idx == '0);
  // R3: no movement without an access
  a_r3_idle: assert property (@(posedge clk) disable iff (rst)
    (!sel_we && !access) |=> $stable(idx));
endmodule

// File: rtl/fbuf_eng_ptr.sv
module fbuf_eng_ptr #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             access,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] cnt;

  assign ptr = start ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (access)
      cnt <= ptr + 1'b1;
    else if (start)
      cnt <= '0;
  end

  // R8: a start with no access points the counter at byte 0
  a_r8_start: assert property (@(posedge clk) disable iff (rst)
    (start && !access) |=> cnt == '0);
  // R8: a start together with an access lands on byte 1
  a_r8_start_access: assert property (@(posedge clk) disable iff (rst)
    (start && access) |=> cnt == {{(IDX_W-1){1'b0}}, 1'b1});
  // R12: the counter returns to zero on reset
  a_r12_reset_cnt: assert property (@(posedge clk) rst |=> cnt == '0);
endmodule

// File: rtl/fbuf_store.sv
module fbuf_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              h_we,
  input  logic [AW-1:0]     h_addr,
  input  logic [DATA_W-1:0] h_d,
  output logic [DATA_W-1:0] h_q,
  input  logic              e_we,
  input  logic [AW-1:0]     e_addr,
  input  logic [DATA_W-1:0] e_d,
  output logic [DATA_W-1:0] e_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (e_we && e_addr == AW'(g))
        mem[g] <= e_d;
      else if (h_we && h_addr == AW'(g))
        mem[g] <= h_d;
    end
  end

  assign h_q = mem[h_addr];
  assign e_q = mem[e_addr];

  // R10: the engine wins a shared byte
  a_r10_engine_wins: assert property (@(posedge clk)
    (h_we && e_we && h_addr == e_addr) |=> mem[$past(e_addr)] == $past(e_d));
  // R11: both writes land on different bytes
  a_r11_both_land: assert property (@(posedge clk)
    (h_we && e_we && h_addr != e_addr) |=>
      (mem[$past(h_addr)] == $past(h_d) && mem[$past(e_addr)] == $past(e_d)));
endmodule

// File: rtl/fbuf_frame_buffer.sv
module fbuf_frame_buffer
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH  = FB_DEPTH,
  parameter int unsigned DATA_W = FB_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              sel_hold,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [IDX_W-1:0]  cur_idx,
  input  logic              eng_start,
  input  logic              eng_wr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_rd,
  output logic [DATA_W-1:0] eng_rdata
);
  logic             host_access;
  logic             eng_access;
  logic [IDX_W-1:0] eng_ptr;
  step_mode_e       step_mode;

  assign host_access = host_rd | host_wr;
  assign eng_access  = eng_rd | eng_wr;

  fbuf_host_ptr #(.IDX_W(IDX_W)) u_host_ptr (
    .clk(clk), .rst(rst),
    .sel_we(sel_we), .sel_idx(sel_idx), .sel_hold(sel_hold),
    .access(host_access), .idx(cur_idx), .mode(step_mode)
  );

  fbuf_eng_ptr #(.IDX_W(IDX_W)) u_eng_ptr (
    .clk(clk), .rst(rst),
    .start(eng_start), .access(eng_access), .ptr(eng_ptr)
  );

  fbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk),
    .h_we(host_wr), .h_addr(cur_idx), .h_d(host_wdata), .h_q(host_rdata),
    .e_we(eng_wr), .e_addr(eng_ptr), .e_d(eng_wdata), .e_q(eng_rdata)
  );

  // R7: a select write overrides the step from a same-cycle access
  a_r7_sel_priority: assert property (@(posedge clk) disable iff (rst)
    (sel_we && host_access) |=> cur_idx == $past(sel_idx));
  // R3: in auto mode an access moves the index by one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!sel_we && host_access && step_mode == STEP_AUTO) |=>
      cur_idx == IDX_W'($past(cur_idx) + 1'b1));
endmodule

// File: tb/tb_fbuf_frame_buffer.sv
module tb_fbuf_frame_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // fields: swe, sidx, shold, rd, wr, wdata, chk, exp_rdata, exp_idx (27 bits)
  typedef struct packed {
    logic       swe;
    logic [2:0] sidx;
    logic       shold;
    logic       rd;
    logic       wr;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] erd;
    logic [2:0] eidx;
  } vec_t;

  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd0}, // R6 auto from 0
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h10,1'b0,8'h00,3'd1}, // R1 R3
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h11,1'b0,8'h00,3'd2},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h12,1'b0,8'h00,3'd3},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h13,1'b0,8'h00,3'd4},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h14,1'b0,8'h00,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h15,1'b0,8'h00,3'd6},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h16,1'b0,8'h00,3'd7},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h17,1'b0,8'h00,3'd0}, // R4 wrap
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h10,3'd1}, // R2 R3
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h11,3'd2},
    {1'b1,3'd5,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,3'd5}, // R6 hold at 5
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h15,3'd5}, // R5
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h15,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,8'h55,1'b0,8'h00,3'd5},
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h55,3'd5}, // R1
    {1'b1,3'd7,1'b0,1'b1,1'b0,8'h00,1'b1,8'h55,3'd7}, // R7 read old idx
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h17,3'd0}, // R4
    {1'b1,3'd3,1'b0,1'b0,1'b1,8'hAA,1'b0,8'h00,3'd3}, // R7 write old idx
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h13,3'd4},
    {1'b1,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd0},
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'hAA,3'd1}, // R7 write landed at 0
    {1'b0,3'd0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,3'd1}, // R3 idle
    {1'b0,3'd0,1'b0,1'b1,1'b1,8'h77,1'b1,8'h11,3'd2}, // R3 rd+wr one step
    {1'b1,3'd1,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,3'd1},
    {1'b0,3'd0,1'b0,1'b1,1'b0,8'h00,1'b1,8'h77,3'd1}  // R1
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_we = 1'b0, sel_hold = 1'b0;
  logic [2:0] sel_idx = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [2:0] cur_idx;
  logic       eng_start = 1'b0, eng_wr = 1'b0, eng_rd = 1'b0;
  logic [7:0] eng_wdata = '0, eng_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbuf_frame_buffer dut (
    .clk(clk), .rst(rst),
    .sel_we(sel_we), .sel_idx(sel_idx), .sel_hold(sel_hold),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cur_idx(cur_idx),
    .eng_start(eng_start), .eng_wr(eng_wr), .eng_wdata(eng_wdata),
    .eng_rd(eng_rd), .eng_rdata(eng_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    sel_we = 0; host_rd = 0; host_wr = 0;
    eng_start = 0; eng_wr = 0; eng_rd = 0;
  endtask

  task automatic set_sel(input logic [2:0] i, input logic h);
    sel_we = 1; sel_idx = i; sel_hold = h;
    tick();
    idle();
  endtask

  task automatic host_read_chk(input string req, input logic [7:0] exp);
    host_rd = 1;
    #1;
    check(req, host_rdata, exp);
    tick();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R12 idx after reset", cur_idx, 0);
    host_rd = 1;
    tick();
    idle();
    check("R12 hold mode after reset", cur_idx, 0);

    for (int i = 0; i < NVEC; i++) begin
      v = vec_t'(VEC[i]);
      sel_we = v.swe; sel_idx = v.sidx; sel_hold = v.shold;
      host_rd = v.rd; host_wr = v.wr; host_wdata = v.wd;
      #1;
      if (v.chk) check($sformatf("R2 vec %0d rdata", i), host_rdata, v.erd);
      tick();
      idle();
      check($sformatf("R3/R5/R6 vec %0d idx", i), cur_idx, v.eidx);
    end

    // R8: engine fills in frame order, then wraps
    eng_start = 1;
    tick();
    idle();
    for (int b = 0; b < 8; b++) begin
      eng_wr = 1; eng_wdata = 8'hE0 + 8'(b);
      tick();
      idle();
    end
    eng_wr = 1; eng_wdata = 8'hE8;
    tick();
    idle();
    set_sel(3'd0, 1'b0);
    host_read_chk("R8 R4 engine wrap byte 0", 8'hE8);
    for (int b = 1; b < 8; b++)
      host_read_chk("R8 frame order", 8'hE0 + 8'(b));

    // R9: engine drains with combinational read data
    eng_start = 1; eng_rd = 1;
    #1;
    check("R9 start read byte 0", eng_rdata, 8'hE8);
    tick();
    idle();
    #1;
    check("R9 read byte 1", eng_rdata, 8'hE1);
    eng_rd = 1;
    tick();
    idle();
    #1;
    check("R9 read byte 2", eng_rdata, 8'hE2);

    // R10: same byte collision
    set_sel(3'd0, 1'b1);
    eng_start = 1; eng_wr = 1; eng_wdata = 8'h22;
    host_wr = 1; host_wdata = 8'h11;
    tick();
    idle();
    #1;
    check("R10 engine wins byte 0", host_rdata, 8'h22);
    // R11: different bytes in one cycle
    eng_wr = 1; eng_wdata = 8'h44;
    host_wr = 1; host_wdata = 8'h33;
    tick();
    idle();
    #1;
    check("R11 host byte 0", host_rdata, 8'h33);
    set_sel(3'd1, 1'b1);
    #1;
    check("R11 engine byte 1", host_rdata, 8'h44);

    // R12: reset in the middle of use
    set_sel(3'd4, 1'b0);
    rst = 1;
    tick();
    rst = 0;
    check("R12 idx after mid reset", cur_idx, 0);
    host_rd = 1;
    tick();
    idle();
    check("R12 hold after mid reset", cur_idx, 0);
    #1;
    check("R12 engine counter reset", eng_rdata, 8'h33);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule